// File: doc/BRIEF.md
# Biquad Cascade Sequencer

This block is a two-channel audio equalizer. One multiply-accumulate datapath is shared by every filter. For each accepted sample pair it walks a fixed list of nine filter slots, first for the left channel and then for the right. Each slot is a second-order section. A slot either runs or is skipped. Which slots run, what each one stands for, and which coefficient set it reads are all decoded at run time from a small group of control bits. The upstream interpolator delivers samples at twice the base audio rate, so each base-rate sample yields two filtered samples per channel.

The slots are: slot 0 is a DC-blocking high-pass, slots 1 to 4 are user filters, slots 5 to 7 are either fixed-role stages (de-emphasis, bass, treble) or extra user filters, and slot 8 is a common user filter. Coefficients are loaded through a simple write port into a shadow bank. That bank is copied into the working bank when a new sample is accepted, so a filter never mixes old and new coefficients within one sample.

Top module: `eq_biquad_seq`

## Requirements
- R1: After reset `out_l`, `out_r` and `out_valid` are 0, and every coefficient and every filter history is 0. A sample processed right after reset, with slot 0 running, therefore produces 0 on both outputs.
- R2: A `smp_stb` pulse seen while the block is idle is accepted. Each accepted strobe produces exactly one `out_valid` pulse, one cycle long, within 128 cycles of the strobe. The left and right results are present on the outputs during that pulse.
- R3: A running slot computes y = b0·x + b1·x1 + b2·x2 − a1·y1 − a2·y2 on its own history for that channel and slot. Coefficients are signed 28-bit with 24 fraction bits. The sum is rounded by adding 2^23 and shifting right arithmetically by 24, then saturated to signed 24 bits. Coefficient addressing: `cw_set` picks set 0 or 1, `cw_slot` picks slot 0..8, and `cw_tap` picks 0=b0, 1=b1, 2=b2, 3=a1, 4=a2.
- R4: Slot 0 runs only when `hpf_skip` is 0. The user-skip bits do not affect it.
- R5: With `coef_link` = 0, channel c reads coefficient set c. Slots 1 to 4 are user filters. Slot 5 runs when `deemph_skip` = 0. Slots 6 and 7 run when `tone_skip[c]` = 0. `lnk_stage_en` has no effect.
- R6: With `coef_link` = 1, both channels read set 0. Slots 5, 6 and 7 run only when `lnk_stage_en` bit 0, 1 and 2 respectively is 1 and the channel's user filters are not skipped.
- R7: Slot 8 runs only when `xover_code` = 0, `dual_band` = 0 and the channel's user filters are not skipped. It always reads set 0.
- R8: `all_user_skip` = 1, or `ch_user_skip[c]` = 1 (bit 0 left, bit 1 right), skips the user filters of that channel: slots 1 to 4, slots 5 to 7 when linked, and slot 8.
- R9: A skipped slot passes its input through unchanged and leaves its history registers untouched. When it later runs again, it resumes from the history it held before it was skipped.
- R10: The control bits and the coefficients are sampled at the accepted strobe. A coefficient write or control change made while a sample is in flight applies from the next accepted strobe.
- R11: A stage whose result exceeds the signed 24-bit range outputs 8388607 or −8388608. That saturated value is also what enters its history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | New sample pair strobe |
| smp_l | input | SW | Left input sample, signed |
| smp_r | input | SW | Right input sample, signed |
| hpf_skip | input | 1 | Skip the DC high-pass (slot 0) |
| coef_link | input | 1 | Share coefficient set 0 across channels; slots 5..7 become user filters |
| all_user_skip | input | 1 | Skip user filters on both channels |
| ch_user_skip | input | 2 | Per-channel user filter skip |
| deemph_skip | input | 1 | Skip de-emphasis role of slot 5 |
| tone_skip | input | 2 | Per-channel skip of bass/treble roles |
| lnk_stage_en | input | 3 | Enables for slots 5..7 when linked |
| xover_code | input | 4 | Crossover selection; slot 8 needs 0 |
| dual_band | input | 1 | Two-band dynamics active; blocks slot 8 |
| cw_en | input | 1 | Coefficient write enable |
| cw_set | input | 1 | Coefficient set for write |
| cw_slot | input | 4 | Slot for write |
| cw_tap | input | 3 | Tap for write |
| cw_data | input | CW | Coefficient value |
| out_l | output | SW | Filtered left sample |
| out_r | output | SW | Filtered right sample |
| out_valid | output | 1 | One-cycle result strobe |

## Verification
The bench goes after the control decode first.
- With the link bit clear, the enables for slots 5 to 7 must be ignored. A design that honoured them would drop the tone stages and shift every output.
- With the link bit set, both channels must read set 0. A design that kept per-channel sets would make the right channel disagree.
- The common slot 8 has three separate ways to be gated: the crossover code, the two-band flag and the user-skip bits.

It also checks state handling across samples.
- A skipped stage must keep its history. A design that cleared or shifted it would produce a wrong first sample after the skip is released.
- A coefficient write and a control change made mid-sample must not affect that sample. An immediate write would corrupt it.
- A huge gain must clip to the 24-bit rails rather than wrap around.

// File: rtl/eq_pkg.sv
package eq_pkg;
    localparam int NCH   = 2;
    localparam int NSLOT = 9;
    localparam int NTAP  = 5;
    localparam int NSET  = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_STEP = 2'd1,
        ST_TAP  = 2'd2,
        ST_WB   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic       hpf_skip;
        logic       coef_link;
        logic       all_user_skip;
        logic [1:0] ch_user_skip;
        logic       deemph_skip;
        logic [1:0] tone_skip;
        logic [2:0] lnk_stage_en;
        logic [3:0] xover_code;
        logic       dual_band;
    } eq_ctl_t;
endpackage

// File: rtl/eq_stage_sel.sv
module eq_stage_sel
    import eq_pkg::*;
(
    input  eq_ctl_t                     ctl,
    output logic [NCH-1:0][NSLOT-1:0]   run
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic user_ok;
        assign user_ok = ~(ctl.all_user_skip | ctl.ch_user_skip[c]);
        for (genvar s = 0; s < NSLOT; s++) begin : g_slot
            if (s == 0) begin : g_hp
                // R4: head high-pass, independent of the user-skip bits
                assign run[c][s] = ~ctl.hpf_skip;
            end else if (s <= 4) begin : g_user
                assign run[c][s] = user_ok;
            end else if (s == 5) begin : g_deemph
                assign run[c][s] = ctl.coef_link ? (ctl.lnk_stage_en[0] & user_ok)
                                                 : ~ctl.deemph_skip;
            end else if (s <= 7) begin : g_tone
                assign run[c][s] = ctl.coef_link ? (ctl.lnk_stage_en[s-5] & user_ok)
                                                 : ~ctl.tone_skip[c];
            end else begin : g_common
                // R7: common slot
                assign run[c][s] = (ctl.xover_code == 4'd0) & ~ctl.dual_band & user_ok;
            end
        end
    end
endmodule

// File: rtl/eq_coef_bank.sv
module eq_coef_bank #(
    parameter  int CW    = 28,
    parameter  int DEPTH = 90,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          commit,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_data
);
    logic [DEPTH-1:0][CW-1:0] shd_d, shd_q, act_d, act_q;

    always_comb begin
        shd_d = shd_q;
        act_d = act_q;
        if (commit) act_d = shd_q;
        if (wr_en && (int'(wr_addr) < DEPTH)) shd_d[wr_addr] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= '0;
            act_q <= '0;
        end else begin
            shd_q <= shd_d;
            act_q <= act_d;
        end
    end

    assign rd_data = (int'(rd_addr) < DEPTH) ? act_q[rd_addr] : '0;

    // R10: working coefficients move only at a sample boundary
    a_r10_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_q));
endmodule

// File: rtl/eq_mac.sv
module eq_mac #(
    parameter  int SW   = 24,
    parameter  int CW   = 28,
    parameter  int FRAC = 24,
    localparam int ACCW = SW + CW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic          neg,
    input  logic [CW-1:0] coef,
    input  logic [SW-1:0] opnd,
    output logic [SW-1:0] y
);
    localparam logic signed [ACCW-1:0] HALF = {{(ACCW-1){1'b0}}, 1'b1} << (FRAC-1);
    localparam logic signed [ACCW-1:0] MAXV = {{(ACCW-SW+1){1'b0}}, {(SW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] MINV = {{(ACCW-SW+1){1'b1}}, {(SW-1){1'b0}}};

    logic signed [ACCW-1:0] acc_d, acc_q, cx, ox, prod, rnd, shf;

    always_comb begin
        cx    = {{(ACCW-CW){coef[CW-1]}}, coef};
        ox    = {{(ACCW-SW){opnd[SW-1]}}, opnd};
        prod  = cx * ox;
        acc_d = acc_q;
        if (clr)     acc_d = '0;
        else if (en) acc_d = neg ? (acc_q - prod) : (acc_q + prod);
        // R3 rounding, R11 saturation
        rnd = acc_q + HALF;
        shf = rnd >>> FRAC;
        if (shf > MAXV)      y = MAXV[SW-1:0];
        else if (shf < MINV) y = MINV[SW-1:0];
        else                 y = shf[SW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R3: a stage's accumulation never restarts mid-stage
    a_r3_clear_not_during_mac: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> !clr);
endmodule

// File: rtl/eq_biquad_seq.sv
module eq_biquad_seq
    import eq_pkg::*;
#(
    parameter int SW   = 24,
    parameter int CW   = 28,
    parameter int FRAC = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_stb,
    input  logic [SW-1:0] smp_l,
    input  logic [SW-1:0] smp_r,
    input  logic          hpf_skip,
    input  logic          coef_link,
    input  logic          all_user_skip,
    input  logic [1:0]    ch_user_skip,
    input  logic          deemph_skip,
    input  logic [1:0]    tone_skip,
    input  logic [2:0]    lnk_stage_en,
    input  logic [3:0]    xover_code,
    input  logic          dual_band,
    input  logic          cw_en,
    input  logic          cw_set,
    input  logic [3:0]    cw_slot,
    input  logic [2:0]    cw_tap,
    input  logic [CW-1:0] cw_data,
    output logic [SW-1:0] out_l,
    output logic [SW-1:0] out_r,
    output logic          out_valid
);
    localparam int DEPTH = NSET * NSLOT * NTAP;
    localparam int AW    = $clog2(DEPTH);

    typedef struct packed {
        seq_state_e                          st;
        logic                                ch;
        logic [3:0]                          slot;
        logic [2:0]                          tap;
        eq_ctl_t                             ctl;
        logic [SW-1:0]                       cur;
        logic [SW-1:0]                       in_r;
        logic [SW-1:0]                       res_l;
        logic [NCH-1:0][NSLOT-1:0][SW-1:0]   x1, x2, y1, y2;
        logic [SW-1:0]                       o_l, o_r;
        logic                                vld;
    } seq_t;

    seq_t s_d, s_q;

    eq_ctl_t                   ctl_in;
    logic [NCH-1:0][NSLOT-1:0] run;
    logic                      commit, wr_ok, set_sel, mac_clr, mac_en, mac_neg;
    logic [AW-1:0]             wr_addr, rd_addr;
    logic [CW-1:0]             rd_data;
    logic [SW-1:0]             opnd, mac_y;

    assign ctl_in = '{hpf_skip: hpf_skip, coef_link: coef_link, all_user_skip: all_user_skip,
                      ch_user_skip: ch_user_skip, deemph_skip: deemph_skip, tone_skip: tone_skip,
                      lnk_stage_en: lnk_stage_en, xover_code: xover_code, dual_band: dual_band};

    assign wr_ok   = cw_en && (int'(cw_slot) < NSLOT) && (int'(cw_tap) < NTAP);
    assign wr_addr = AW'((int'(cw_set) * NSLOT + int'(cw_slot)) * NTAP + int'(cw_tap));
    assign set_sel = (s_q.ctl.coef_link || int'(s_q.slot) == NSLOT-1) ? 1'b0 : s_q.ch;
    assign rd_addr = AW'((int'(set_sel) * NSLOT + int'(s_q.slot)) * NTAP + int'(s_q.tap));

    eq_stage_sel u_sel (.ctl(s_q.ctl), .run(run));

    eq_coef_bank #(.CW(CW), .DEPTH(DEPTH)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_addr(wr_addr), .wr_data(cw_data),
        .commit(commit), .rd_addr(rd_addr), .rd_data(rd_data));

    eq_mac #(.SW(SW), .CW(CW), .FRAC(FRAC)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(mac_clr), .en(mac_en), .neg(mac_neg),
        .coef(rd_data), .opnd(opnd), .y(mac_y));

    always_comb begin
        case (s_q.tap)
            3'd0:    opnd = s_q.cur;
            3'd1:    opnd = s_q.x1[s_q.ch][s_q.slot];
            3'd2:    opnd = s_q.x2[s_q.ch][s_q.slot];
            3'd3:    opnd = s_q.y1[s_q.ch][s_q.slot];
            default: opnd = s_q.y2[s_q.ch][s_q.slot];
        endcase
        mac_neg = (s_q.tap >= 3'd3);
    end

    function automatic seq_t advance(seq_t s);
        seq_t n;
        n = s;
        if (int'(s.slot) == NSLOT-1) begin
            n.slot = '0;
            if (!s.ch) begin
                n.res_l = s.cur;
                n.ch    = 1'b1;
                n.cur   = s.in_r;
                n.st    = ST_STEP;
            end else begin
                n.o_l = s.res_l;
                n.o_r = s.cur;
                n.vld = 1'b1;
                n.st  = ST_IDLE;
            end
        end else begin
            n.slot = s.slot + 4'd1;
            n.st   = ST_STEP;
        end
        return n;
    endfunction

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        mac_clr = 1'b0;
        mac_en  = 1'b0;
        commit  = 1'b0;
        case (s_q.st)
            ST_IDLE: if (smp_stb) begin
                commit   = 1'b1;
                s_d.ctl  = ctl_in;
                s_d.cur  = smp_l;
                s_d.in_r = smp_r;
                s_d.ch   = 1'b0;
                s_d.slot = '0;
                s_d.st   = ST_STEP;
            end
            ST_STEP: begin
                if (run[s_q.ch][s_q.slot]) begin
                    mac_clr = 1'b1;
                    s_d.tap = '0;
                    s_d.st  = ST_TAP;
                end else begin
                    s_d = advance(s_d);
                end
            end
            ST_TAP: begin
                mac_en = 1'b1;
                if (int'(s_q.tap) == NTAP-1) s_d.st  = ST_WB;
                else                         s_d.tap = s_q.tap + 3'd1;
            end
            default: begin
                s_d.x2[s_q.ch][s_q.slot] = s_q.x1[s_q.ch][s_q.slot];
                s_d.x1[s_q.ch][s_q.slot] = s_q.cur;
                s_d.y2[s_q.ch][s_q.slot] = s_q.y1[s_q.ch][s_q.slot];
                s_d.y1[s_q.ch][s_q.slot] = mac_y;
                s_d.cur = mac_y;
                s_d     = advance(s_d);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_l     = s_q.o_l;
    assign out_r     = s_q.o_r;
    assign out_valid = s_q.vld;

    // R2: result strobe is a single-cycle pulse
    a_r2_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R10: control captured at the strobe stays fixed while a sample is in flight
    a_r10_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE) |=> $stable(s_q.ctl));

    // R9: skipping a slot leaves every history register as it was
    a_r9_skip_keeps_history: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_STEP && !run[s_q.ch][s_q.slot]) |=>
            ($stable(s_q.x1) && $stable(s_q.x2) && $stable(s_q.y1) && $stable(s_q.y2)));
endmodule

// File: tb/sim_eq_biquad_seq.sv
`timescale 1ns/1ps
module sim_eq_biquad_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        smp_stb = 1'b0;
    logic [23:0] smp_l = '0, smp_r = '0;
    // bench control word: [0] hpf_skip [1] coef_link [2] all_user_skip [4:3] ch_user_skip
    // [5] deemph_skip [7:6] tone_skip [10:8] lnk_stage_en [14:11] xover_code [15] dual_band
    logic [15:0] ctl = '0;
    logic        cw_en = 1'b0, cw_set = 1'b0;
    logic [3:0]  cw_slot = '0;
    logic [2:0]  cw_tap = '0;
    logic [27:0] cw_data = '0;
    logic signed [23:0] out_l, out_r;
    logic        out_valid;

    eq_biquad_seq u0 (
        .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
        .hpf_skip(ctl[0]), .coef_link(ctl[1]), .all_user_skip(ctl[2]), .ch_user_skip(ctl[4:3]),
        .deemph_skip(ctl[5]), .tone_skip(ctl[7:6]), .lnk_stage_en(ctl[10:8]),
        .xover_code(ctl[14:11]), .dual_band(ctl[15]),
        .cw_en(cw_en), .cw_set(cw_set), .cw_slot(cw_slot), .cw_tap(cw_tap), .cw_data(cw_data),
        .out_l(out_l), .out_r(out_r), .out_valid(out_valid));

    int n_run = 0, n_fail = 0;
    longint cf [2][9][5];
    longint hx1 [2][9], hx2 [2][9], hy1 [2][9], hy2 [2][9];

    localparam int NV = 10;
    localparam logic [15:0] VCTL [NV] = '{16'h0000, 16'h0001, 16'h0702, 16'h0202, 16'h0740,
                                         16'h0004, 16'h0010, 16'h1800, 16'h8020, 16'h050A};
    localparam int VIL [NV] = '{100000, -250000, 31415, 200000, -5, 7, 150000, -123456, 65536, 1};
    localparam int VIR [NV] = '{-80000, 120000, -27182, 0, 250000, -300000, 99, 4242, -65536, -1};

    function automatic string row_tag(int i);
        case (i)
            0: return "R3 R5 all slots";
            1: return "R4 hpf skip";
            2: return "R6 linked all enabled";
            3: return "R6 linked one enabled";
            4: return "R5 enables ignored";
            5: return "R8 global user skip";
            6: return "R8 right user skip";
            7: return "R7 crossover code";
            8: return "R7 dual band";
            default: return "R6 R8 linked left skip";
        endcase
    endfunction

    function automatic bit exp_run(int c, int s);
        bit uok;
        uok = !(ctl[2] | ctl[3+c]);
        if (s == 0)      return !ctl[0];
        else if (s <= 4) return uok;
        else if (s == 5) return ctl[1] ? (ctl[8] & uok) : !ctl[5];
        else if (s <= 7) return ctl[1] ? (ctl[8+s-5] & uok) : !ctl[6+c];
        else             return (ctl[14:11] == 4'd0) && !ctl[15] && uok;
    endfunction

    function automatic longint sat24(longint v);
        if (v > 8388607)  return 8388607;
        if (v < -8388608) return -8388608;
        return v;
    endfunction

    task automatic model(input longint il, input longint ir, output longint el, output longint er);
        for (int c = 0; c < 2; c++) begin
            longint v;
            v = (c == 0) ? il : ir;
            for (int s = 0; s < 9; s++) begin
                if (exp_run(c, s)) begin
                    int st;
                    longint acc, y;
                    st  = (ctl[1] || s == 8) ? 0 : c;
                    acc = cf[st][s][0]*v + cf[st][s][1]*hx1[c][s] + cf[st][s][2]*hx2[c][s]
                        - cf[st][s][3]*hy1[c][s] - cf[st][s][4]*hy2[c][s];
                    y = sat24((acc + (64'sd1 <<< 23)) >>> 24);
                    hx2[c][s] = hx1[c][s];
                    hx1[c][s] = v;
                    hy2[c][s] = hy1[c][s];
                    hy1[c][s] = y;
                    v = y;
                end
            end
            if (c == 0) el = v;
            else        er = v;
        end
    endtask

    task automatic check(string req, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wcoef(int st, int s, int t, longint v);
        @(negedge clk);
        cw_en = 1'b1; cw_set = st[0]; cw_slot = s[3:0]; cw_tap = t[2:0]; cw_data = v[27:0];
        @(negedge clk);
        cw_en = 1'b0;
        cf[st][s][t] = v;
    endtask

    task automatic wait_valid(output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (out_valid) begin ok = 1'b1; break; end
        end
    endtask

    task automatic strobe(input longint il, input longint ir, output longint el, output longint er);
        @(negedge clk);
        smp_l = il[23:0]; smp_r = ir[23:0]; smp_stb = 1'b1;
        model(il, ir, el, er);
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic run_one(string req, longint il, longint ir);
        longint el, er;
        bit ok;
        strobe(il, ir, el, er);
        wait_valid(ok);
        if (!ok) check({req, " R2 no result"}, 0, 1);
        else begin
            check(req, out_l, el);
            check(req, out_r, er);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        longint el, er;
        bit ok;
        for (int a = 0; a < 2; a++)
            for (int s = 0; s < 9; s++) begin
                hx1[a][s] = 0; hx2[a][s] = 0; hy1[a][s] = 0; hy2[a][s] = 0;
                for (int t = 0; t < 5; t++) cf[a][s][t] = 0;
            end
        repeat (3) @(negedge clk);
        check("R1 reset out_l", out_l, 0);
        check("R1 reset out_r", out_r, 0);
        check("R1 reset out_valid", out_valid, 0);
        rst_n = 1'b1;
        run_one("R1 zero coefficients", 12345, -777);

        for (int st = 0; st < 2; st++)
            for (int s = 0; s < 9; s++)
                for (int t = 0; t < 5; t++) begin
                    longint v;
                    case (t)
                        0: v = (64'sd1 <<< 24) - st * (64'sd1 <<< 21);
                        1: v = (st != 0 ? -1 : 1) * (s + 1) * (64'sd1 <<< 19);
                        2: v = 64'sd1 <<< 18;
                        3: v = (s % 2 != 0) ? -(64'sd1 <<< 21) : (64'sd1 <<< 20);
                        default: v = 64'sd1 <<< 18;
                    endcase
                    wcoef(st, s, t, v);
                end

        for (int i = 0; i < NV; i++) begin
            ctl = VCTL[i];
            run_one(row_tag(i), VIL[i], VIR[i]);
        end

        // R2: the result strobe lasts one cycle
        ctl = 16'h0000;
        run_one("R2 result", 4000, -4000);
        @(negedge clk);
        check("R2 valid drops", out_valid, 0);

        // R9: skipped slots keep their history across skipped samples
        ctl = 16'h0004;
        run_one("R9 skip phase", 50000, -60000);
        run_one("R9 skip phase", -70000, 80000);
        ctl = 16'h0000;
        run_one("R9 resume", 90000, 10000);

        // R10: mid-sample coefficient write and control change apply next strobe
        ctl = 16'h0000;
        strobe(300000, -300000, el, er);
        repeat (4) @(negedge clk);
        ctl = 16'h0001;
        wcoef(0, 8, 0, (64'sd1 <<< 27) - 1);
        wait_valid(ok);
        if (!ok) check("R10 R2 no result", 0, 1);
        else begin
            check("R10 old coefficients l", out_l, el);
            check("R10 old coefficients r", out_r, er);
        end
        // R11: the new huge gain in slot 8 drives both outputs to the rails
        run_one("R11 saturation", 900000, -900000);
        run_one("R11 saturation follow", 800000, -850000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule